// File: doc/BRIEF.md
# Status Pin Multiplexer

This block drives two general-purpose output pins from a set of internal status flags, a lock indicator, a serial clock, a ready flag, an oscillator-stable flag, constant levels, high impedance, or one of sixteen divided copies of the reference clock. Each pin has a select register and an invert bit. Both are loaded through a small configuration port. The invert bit acts after the source is chosen, so a pin can show any source at either polarity. High impedance is never inverted.

Pin 1 shares its wire with the SPI data-out line. While the SPI chip select is active (low), the pin carries the SPI data-out value. While chip select is high, it carries its own selected source. In sleep mode, both pins go to fixed states. Pin 0 can also be used as a serial data input; while it is, its driver is released. The block has no data stream, so every port is a plain level or strobe with no handshake.

All sixteen dividers run freely from reset release. Only one divided clock can reach a pin at a time. Pin 0 has priority for that clock.

Top module: `status_pin_mux`

## Requirements
- R1: After reset, pin 0 has select 0x3F (reference clock divided by 192) and pin 1 has select 0x2E (released). Both invert bits are 0. Pin 0 is driven and pin 1 is not.
- R2: A high `cfg_we0` or `cfg_we1` at a rising clock edge loads `cfg_sel` and `cfg_inv` into that pin's registers. The new setting shows on the pin in the following cycle.
- R3: Several select codes pass an input level straight to the pin: 0x02 gives `fifo_at_thr`, 0x0A gives `lock_det`, 0x0B gives `ser_clk`, 0x29 gives `chip_rdy` and 0x2B gives `xosc_stable`. Code 0x2D gives the inverse of `pin0_as_input`. Any select code below 0x30 that has no source assigned gives 0.
- R4: Code 0x03 shows a full flag with hysteresis. The flag sets at the edge after `fifo_full` is high. It clears at the edge after `fifo_full` and `fifo_at_thr` are both low. Otherwise it holds.
- R5: Code 0x05 shows an underflow flag. `tx_underflow` sets it and `tx_flush` clears it; the clear wins if both arrive together. Code 0x06 shows a packet flag. `sync_sent` sets it, and `pkt_end` or `tx_underflow` clears it; the clear wins. Each of these flags changes at the edge after its input.
- R6: Code 0x2E releases the pin: its enable and its value are both 0, whatever the invert bit is. Every other code drives the pin with the source value XOR the invert bit. Code 0x2F is a source of 0.
- R7: Codes 0x32 to 0x3F select the reference clock divided by 2, 3, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128 and 192, in that order. Call the ratio N and let k be the number of rising edges since reset release. The divided clock is high when k mod N is less than N/2 (rounded down).
- R8: Code 0x30 outputs the reference clock itself. Code 0x31 outputs one pulse every 1.5 input periods. It is high in the high half of the cycle where k mod 3 = 0, and in the low half of the cycle where k mod 3 = 1. It is low in every other half-cycle.
- R9: Pin 1 receives a divided clock only while pin 0's select is below 0x30. Otherwise its source is 0, and its invert bit still applies.
- R10: While `spi_cs_n` is low and the block is not asleep, pin 1 is driven with `spi_miso`.
- R11: While `sleep` is high, pin 1 is driven with 1 and pin 0 is released (value 0). This takes priority over every other setting.
- R12: While `pin0_as_input` is high and the block is not asleep, pin 0 is released (enable 0, value 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also the source of all divided clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we0 | input | 1 | Load strobe for the pin 0 select and invert bit |
| cfg_we1 | input | 1 | Load strobe for the pin 1 select and invert bit |
| cfg_sel | input | 6 | Select code to load |
| cfg_inv | input | 1 | Invert bit to load |
| fifo_at_thr | input | 1 | Transmit FIFO level is at or above its threshold |
| fifo_full | input | 1 | Transmit FIFO is full |
| tx_underflow | input | 1 | Pulse: the transmit FIFO underflowed |
| tx_flush | input | 1 | Pulse: the transmit FIFO was flushed |
| sync_sent | input | 1 | Pulse: the sync word has gone out |
| pkt_end | input | 1 | Pulse: the end of the packet |
| lock_det | input | 1 | Lock detector level |
| ser_clk | input | 1 | Serial data clock |
| chip_rdy | input | 1 | Chip-ready flag |
| xosc_stable | input | 1 | Oscillator-stable flag |
| pin0_as_input | input | 1 | Pin 0 is acting as a serial data input |
| sleep | input | 1 | Sleep mode |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_miso | input | 1 | SPI data-out value that shares pin 1 |
| pin0_out | output | 1 | Pin 0 value |
| pin0_oe | output | 1 | Pin 0 output enable |
| pin1_out | output | 1 | Pin 1 value |
| pin1_oe | output | 1 | Pin 1 output enable |

## Verification
A reference model predicts both pins in every half-cycle, so waveform faults are caught by phase, not only by level. Each divider ratio is held long enough to see whole periods. This separates a wrong ratio, a wrong duty split or a wrong code order, and the half-cycle samples show the shape of the /1 and /1.5 outputs. The flag codes are driven with set-then-clear and set-and-clear-together sequences, which tell hysteresis and clear priority apart from plain pass-through. Sleep, SPI chip select, input mode and clock contention are each applied on top of active settings, to show which override wins and that the invert bit still acts on a pin that lost the clock.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int SEL_W = 6;
  localparam int N_DIV = 16;

  localparam logic [SEL_W-1:0] CODE_FIFO_THR  = 6'h02;
  localparam logic [SEL_W-1:0] CODE_FIFO_FULL = 6'h03;
  localparam logic [SEL_W-1:0] CODE_UNDERFLOW = 6'h05;
  localparam logic [SEL_W-1:0] CODE_PKT       = 6'h06;
  localparam logic [SEL_W-1:0] CODE_LOCK      = 6'h0A;
  localparam logic [SEL_W-1:0] CODE_SCLK      = 6'h0B;
  localparam logic [SEL_W-1:0] CODE_RDY       = 6'h29;
  localparam logic [SEL_W-1:0] CODE_XSTB      = 6'h2B;
  localparam logic [SEL_W-1:0] CODE_DIN_EN_N  = 6'h2D;
  localparam logic [SEL_W-1:0] CODE_HIZ       = 6'h2E;
  localparam logic [SEL_W-1:0] CODE_LOW       = 6'h2F;
  localparam logic [SEL_W-1:0] CODE_DIV_BASE  = 6'h30;
  localparam logic [SEL_W-1:0] RST_SEL0       = 6'h3F;
  localparam logic [SEL_W-1:0] RST_SEL1       = 6'h2E;

  typedef struct packed {
    logic fifo_thr;
    logic full_hold;
    logic underflow;
    logic pkt_active;
    logic lock;
    logic sclk;
    logic rdy;
    logic xstable;
    logic din_en_n;
  } status_t;

  // Integer ratios: even slots are powers of two, odd slots three times a power of two.
  function automatic int div_ratio(input int idx);
    if (idx < 2) return 1;
    if (idx % 2 == 0) return 1 << (idx / 2);
    return 3 << ((idx - 3) / 2);
  endfunction
endpackage

// File: rtl/spm_clkdiv_bank.sv
module spm_clkdiv_bank
  import spm_pkg::*;
#(
  parameter int NDIV = N_DIV
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [NDIV-1:0] div_o
);

  for (genvar i = 0; i < NDIV; i++) begin : g_div
    if (i == 0) begin : g_pass
      assign div_o[i] = clk;
    end else if (i == 1) begin : g_frac
      // One pulse per 1.5 input periods: high half of phase 0, low half of phase 1.
      logic [1:0] c3;
      logic       n_hi;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              c3 <= 2'd0;
        else if (c3 == 2'd2)     c3 <= 2'd0;
        else                     c3 <= c3 + 2'd1;
      end
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) n_hi <= 1'b0;
        else        n_hi <= (c3 == 2'd1);
      end
      assign div_o[i] = (clk & (c3 == 2'd0)) | (~clk & n_hi);

      // R8: the falling-edge stage tracks the rising-edge phase counter
      p_frac_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        n_hi == (c3 == 2'd1));
    end else begin : g_int
      localparam int N  = div_ratio(i);
      localparam int CW = $clog2(N);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (cnt == CW'(N - 1))  cnt <= '0;
        else                         cnt <= cnt + 1'b1;
      end
      assign div_o[i] = (cnt < CW'(N / 2));
    end
  end

endmodule

// File: rtl/spm_tx_flags.sv
module spm_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_at_thr,
  input  logic fifo_full,
  input  logic tx_underflow,
  input  logic tx_flush,
  input  logic sync_sent,
  input  logic pkt_end,
  output logic full_hold_o,
  output logic underflow_o,
  output logic pkt_active_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_hold_o  <= 1'b0;
      underflow_o  <= 1'b0;
      pkt_active_o <= 1'b0;
    end else begin
      if (fifo_full)         full_hold_o <= 1'b1;
      else if (!fifo_at_thr) full_hold_o <= 1'b0;

      if (tx_flush)          underflow_o <= 1'b0;
      else if (tx_underflow) underflow_o <= 1'b1;

      if (pkt_end || tx_underflow) pkt_active_o <= 1'b0;
      else if (sync_sent)          pkt_active_o <= 1'b1;
    end
  end

  p_full_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |=> full_hold_o);
  p_full_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_full && !fifo_at_thr) |=> !full_hold_o);
  p_full_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_full && fifo_at_thr) |=> $stable(full_hold_o));
  p_udf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_underflow && !tx_flush) |=> underflow_o);
  p_pkt_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end || tx_underflow) |=> !pkt_active_o);

endmodule

// File: rtl/spm_pin_sel.sv
module spm_pin_sel
  import spm_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             inv,
  input  status_t          st,
  input  logic             clk_in,
  output logic             val_o,
  output logic             drive_o
);

  logic raw;
  logic is_hiz;

  always_comb begin
    is_hiz = (sel == CODE_HIZ);
    case (sel)
      CODE_FIFO_THR:  raw = st.fifo_thr;
      CODE_FIFO_FULL: raw = st.full_hold;
      CODE_UNDERFLOW: raw = st.underflow;
      CODE_PKT:       raw = st.pkt_active;
      CODE_LOCK:      raw = st.lock;
      CODE_SCLK:      raw = st.sclk;
      CODE_RDY:       raw = st.rdy;
      CODE_XSTB:      raw = st.xstable;
      CODE_DIN_EN_N:  raw = st.din_en_n;
      CODE_LOW:       raw = 1'b0;
      default:        raw = (sel >= CODE_DIV_BASE) ? clk_in : 1'b0;
    endcase
    val_o   = is_hiz ? 1'b0 : (raw ^ inv);
    drive_o = ~is_hiz;
  end

endmodule

// File: rtl/status_pin_mux.sv
module status_pin_mux
  import spm_pkg::*;
#(
  parameter int NDIV = N_DIV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we0,
  input  logic             cfg_we1,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             cfg_inv,
  input  logic             fifo_at_thr,
  input  logic             fifo_full,
  input  logic             tx_underflow,
  input  logic             tx_flush,
  input  logic             sync_sent,
  input  logic             pkt_end,
  input  logic             lock_det,
  input  logic             ser_clk,
  input  logic             chip_rdy,
  input  logic             xosc_stable,
  input  logic             pin0_as_input,
  input  logic             sleep,
  input  logic             spi_cs_n,
  input  logic             spi_miso,
  output logic             pin0_out,
  output logic             pin0_oe,
  output logic             pin1_out,
  output logic             pin1_oe
);

  localparam int IDX_W = $clog2(NDIV);

  logic [SEL_W-1:0] sel0_q, sel1_q;
  logic             inv0_q, inv1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel0_q <= RST_SEL0;
      sel1_q <= RST_SEL1;
      inv0_q <= 1'b0;
      inv1_q <= 1'b0;
    end else begin
      if (cfg_we0) begin
        sel0_q <= cfg_sel;
        inv0_q <= cfg_inv;
      end
      if (cfg_we1) begin
        sel1_q <= cfg_sel;
        inv1_q <= cfg_inv;
      end
    end
  end

  logic [NDIV-1:0] div_bus;

  spm_clkdiv_bank #(.NDIV(NDIV)) u_divs (
    .clk   (clk),
    .rst_n (rst_n),
    .div_o (div_bus)
  );

  logic full_hold, underflow, pkt_active;

  spm_tx_flags u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_at_thr  (fifo_at_thr),
    .fifo_full    (fifo_full),
    .tx_underflow (tx_underflow),
    .tx_flush     (tx_flush),
    .sync_sent    (sync_sent),
    .pkt_end      (pkt_end),
    .full_hold_o  (full_hold),
    .underflow_o  (underflow),
    .pkt_active_o (pkt_active)
  );

  status_t st;
  always_comb begin
    st.fifo_thr   = fifo_at_thr;
    st.full_hold  = full_hold;
    st.underflow  = underflow;
    st.pkt_active = pkt_active;
    st.lock       = lock_det;
    st.sclk       = ser_clk;
    st.rdy        = chip_rdy;
    st.xstable    = xosc_stable;
    st.din_en_n   = ~pin0_as_input;
  end

  // Single divided-clock path; pin 0 wins when both ask.
  logic             want0, want1, grant1;
  logic [IDX_W-1:0] div_idx;
  logic             clk_pick, clk0_in, clk1_in;

  always_comb begin
    want0    = (sel0_q >= CODE_DIV_BASE);
    want1    = (sel1_q >= CODE_DIV_BASE);
    grant1   = want1 & ~want0;
    div_idx  = want0 ? sel0_q[IDX_W-1:0] : sel1_q[IDX_W-1:0];
    clk_pick = div_bus[div_idx];
    clk0_in  = want0  & clk_pick;
    clk1_in  = grant1 & clk_pick;
  end

  logic v0, d0, v1, d1;

  spm_pin_sel u_sel0 (
    .sel     (sel0_q),
    .inv     (inv0_q),
    .st      (st),
    .clk_in  (clk0_in),
    .val_o   (v0),
    .drive_o (d0)
  );

  spm_pin_sel u_sel1 (
    .sel     (sel1_q),
    .inv     (inv1_q),
    .st      (st),
    .clk_in  (clk1_in),
    .val_o   (v1),
    .drive_o (d1)
  );

  // Override chain: sleep, then the pin-specific sharing, then the selection.
  always_comb begin
    if (sleep || pin0_as_input) begin
      pin0_out = 1'b0;
      pin0_oe  = 1'b0;
    end else begin
      pin0_out = v0;
      pin0_oe  = d0;
    end
    if (sleep) begin
      pin1_out = 1'b1;
      pin1_oe  = 1'b1;
    end else if (!spi_cs_n) begin
      pin1_out = spi_miso;
      pin1_oe  = 1'b1;
    end else begin
      pin1_out = v1;
      pin1_oe  = d1;
    end
  end

  p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we0 |=> (sel0_q == $past(cfg_sel)));
  p_one_clock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && spi_cs_n && want0 && want1 && !inv1_q) |-> !pin1_out);
  p_spi_share_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !spi_cs_n) |-> (pin1_oe && (pin1_out == spi_miso)));
  p_sleep_pins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (pin1_out && pin1_oe && !pin0_oe));
  p_pin0_input_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && pin0_as_input) |-> (!pin0_oe && !pin0_out));

endmodule

// File: tb/status_pin_mux_bench.sv
`timescale 1ns/1ps
module status_pin_mux_bench;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       cfg_we0 = 0, cfg_we1 = 0, cfg_inv = 0;
  logic [5:0] cfg_sel = '0;
  logic fifo_at_thr = 0, fifo_full = 0, tx_underflow = 0, tx_flush = 0;
  logic sync_sent = 0, pkt_end = 0, lock_det = 0, ser_clk = 0;
  logic chip_rdy = 0, xosc_stable = 0, pin0_as_input = 0, sleep = 0;
  logic spi_cs_n = 1, spi_miso = 0;
  logic pin0_out, pin0_oe, pin1_out, pin1_oe;

  status_pin_mux u_status_pin_mux (
    .clk(clk), .rst_n(rst_n), .cfg_we0(cfg_we0), .cfg_we1(cfg_we1),
    .cfg_sel(cfg_sel), .cfg_inv(cfg_inv), .fifo_at_thr(fifo_at_thr),
    .fifo_full(fifo_full), .tx_underflow(tx_underflow), .tx_flush(tx_flush),
    .sync_sent(sync_sent), .pkt_end(pkt_end), .lock_det(lock_det),
    .ser_clk(ser_clk), .chip_rdy(chip_rdy), .xosc_stable(xosc_stable),
    .pin0_as_input(pin0_as_input), .sleep(sleep), .spi_cs_n(spi_cs_n),
    .spi_miso(spi_miso), .pin0_out(pin0_out), .pin0_oe(pin0_oe),
    .pin1_out(pin1_out), .pin1_oe(pin1_oe)
  );

  // Ratios for codes 0x30..0x3F; 0 marks the 1.5 case.
  int ratio_tab [16] = '{1, 0, 2, 3, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 192};

  int     checks = 0, errors = 0;
  string  cur_req = "R1";
  bit     done = 0;

  // Reference model state
  logic [5:0] m_sel0 = 6'h3F, m_sel1 = 6'h2E;
  logic       m_inv0 = 0, m_inv1 = 0;
  logic       m_full = 0, m_udf = 0, m_pkt = 0;
  longint     k = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel0 = 6'h3F; m_sel1 = 6'h2E; m_inv0 = 0; m_inv1 = 0;
      m_full = 0; m_udf = 0; m_pkt = 0; k = 0;
    end else begin
      k = k + 1;
      if (fifo_full) m_full = 1; else if (!fifo_at_thr) m_full = 0;
      if (tx_flush) m_udf = 0; else if (tx_underflow) m_udf = 1;
      if (pkt_end || tx_underflow) m_pkt = 0; else if (sync_sent) m_pkt = 1;
      if (cfg_we0) begin m_sel0 = cfg_sel; m_inv0 = cfg_inv; end
      if (cfg_we1) begin m_sel1 = cfg_sel; m_inv1 = cfg_inv; end
    end
  end

  function automatic logic div_ref(int idx, logic ph);
    int n;
    if (idx == 0) return ph;
    if (idx == 1) return ((k % 3 == 0) && ph) || ((k % 3 == 1) && !ph);
    n = ratio_tab[idx];
    return (k % n) < (n / 2);
  endfunction

  function automatic logic [1:0] pin_ref(logic [5:0] s, logic iv, logic clk_ok, logic ph);
    logic r;
    if (s == 6'h2E) return 2'b00;
    case (s)
      6'h02: r = fifo_at_thr;
      6'h03: r = m_full;
      6'h05: r = m_udf;
      6'h06: r = m_pkt;
      6'h0A: r = lock_det;
      6'h0B: r = ser_clk;
      6'h29: r = chip_rdy;
      6'h2B: r = xosc_stable;
      6'h2D: r = !pin0_as_input;
      default: r = (s >= 6'h30 && clk_ok) ? div_ref(int'(s) - 48, ph) : 1'b0;
    endcase
    return {r ^ iv, 1'b1};
  endfunction

  task automatic compare(logic ph);
    logic [3:0] exp, got;
    logic [1:0] e0, e1;
    if (sleep || pin0_as_input) e0 = 2'b00;
    else e0 = pin_ref(m_sel0, m_inv0, 1'b1, ph);
    if (sleep) e1 = 2'b11;
    else if (!spi_cs_n) e1 = {spi_miso, 1'b1};
    else e1 = pin_ref(m_sel1, m_inv1, m_sel0 < 6'h30, ph);
    exp = {e0, e1};
    got = {pin0_out, pin0_oe, pin1_out, pin1_oe};
    checks++;
    if (got !== exp) begin
      errors++;
      if (errors < 20)
        $display("FAIL %s t=%0t sel0=%h sel1=%h got=%b expected=%b",
                 cur_req, $time, m_sel0, m_sel1, got, exp);
    end
  endtask

  always @(posedge clk) begin #2; if (!done) compare(1'b1); end
  always @(negedge clk) begin #2; if (!done) compare(1'b0); end

  task automatic finish_run;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not end, got cycle %0d expected below 150000", cyc);
      finish_run();
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask
  task automatic run(int n);
    repeat (n) tick();
  endtask
  task automatic wr(int pin, logic [5:0] s, logic iv);
    tick();
    cfg_sel = s; cfg_inv = iv;
    if (pin == 0) cfg_we0 = 1; else cfg_we1 = 1;
    tick();
    cfg_we0 = 0; cfg_we1 = 0;
  endtask

  initial begin
    // R1: defaults while held in reset and after release
    cur_req = "R1";
    run(3);
    rst_n = 1;
    run(400);

    // R2: loading each pin
    cur_req = "R2";
    wr(0, 6'h2F, 1'b1); run(4);
    wr(1, 6'h2F, 1'b0); run(4);

    // R6: release and constant levels with invert
    cur_req = "R6";
    wr(0, 6'h2E, 1'b1); run(4);
    wr(1, 6'h2E, 1'b1); run(4);
    wr(0, 6'h2F, 1'b0); run(4);

    // R3: pass-through codes and unused codes
    cur_req = "R3";
    wr(0, 6'h0A, 1'b0); lock_det = 1; run(3); lock_det = 0; run(3);
    wr(0, 6'h0B, 1'b1); for (int i = 0; i < 8; i++) begin ser_clk = ~ser_clk; tick(); end
    wr(0, 6'h29, 1'b0); chip_rdy = 1; run(3);
    wr(0, 6'h2B, 1'b0); xosc_stable = 1; run(3);
    wr(0, 6'h02, 1'b0); fifo_at_thr = 1; run(3); fifo_at_thr = 0; run(2);
    lock_det = 1; ser_clk = 1; fifo_at_thr = 1;
    wr(0, 6'h00, 1'b0); run(2);
    wr(0, 6'h07, 1'b0); run(2);
    wr(0, 6'h1F, 1'b0); run(2);
    wr(0, 6'h28, 1'b0); run(2);
    fifo_at_thr = 0; lock_det = 0; ser_clk = 0;

    // R3 and R12: input-mode inverse on pin 1, pin 0 released
    cur_req = "R12";
    wr(1, 6'h2D, 1'b0); wr(0, 6'h3D, 1'b0);
    pin0_as_input = 1; run(6); pin0_as_input = 0; run(4);

    // R4: full flag hysteresis on pin 1
    cur_req = "R4";
    wr(0, 6'h2F, 1'b0);
    wr(1, 6'h03, 1'b0);
    fifo_at_thr = 1; run(3);
    fifo_full = 1; tick(); fifo_full = 0; run(4);
    fifo_at_thr = 0; run(3);
    fifo_full = 1; fifo_at_thr = 0; tick(); fifo_full = 0; run(3);

    // R5: underflow and packet flags
    cur_req = "R5";
    wr(0, 6'h05, 1'b0);
    tx_underflow = 1; tick(); tx_underflow = 0; run(3);
    tx_flush = 1; tick(); tx_flush = 0; run(2);
    tx_underflow = 1; tx_flush = 1; tick(); tx_underflow = 0; tx_flush = 0; run(2);
    wr(0, 6'h06, 1'b0);
    sync_sent = 1; tick(); sync_sent = 0; run(3);
    pkt_end = 1; tick(); pkt_end = 0; run(2);
    sync_sent = 1; tick(); sync_sent = 0; run(2);
    tx_underflow = 1; tick(); tx_underflow = 0; run(2);
    sync_sent = 1; pkt_end = 1; tick(); sync_sent = 0; pkt_end = 0; run(2);
    tx_flush = 1; tick(); tx_flush = 0;

    // R7: integer ratios on pin 0
    cur_req = "R7";
    for (int c = 50; c < 64; c++) begin
      wr(0, 6'(c), 1'b0); run(400);
    end
    wr(0, 6'h36, 1'b1); run(40);

    // R8: direct and 1.5 ratio, plus on pin 1
    cur_req = "R8";
    wr(0, 6'h30, 1'b0); run(20);
    wr(0, 6'h31, 1'b0); run(30);
    wr(0, 6'h31, 1'b1); run(12);
    wr(0, 6'h2F, 1'b0); wr(1, 6'h31, 1'b0); run(30);

    // R9: contention for the divided clock
    cur_req = "R9";
    wr(0, 6'h35, 1'b0); wr(1, 6'h33, 1'b0); run(50);
    wr(1, 6'h33, 1'b1); run(20);
    wr(0, 6'h2E, 1'b0); run(50);

    // R10: SPI sharing over a pass-through selection
    cur_req = "R10";
    wr(1, 6'h0A, 1'b1);
    spi_cs_n = 0;
    for (int i = 0; i < 6; i++) begin spi_miso = ~spi_miso; tick(); end
    spi_cs_n = 1; run(4);

    // R11: sleep over clock and SPI settings
    cur_req = "R11";
    wr(0, 6'h3C, 1'b0);
    sleep = 1; run(8);
    spi_cs_n = 0; pin0_as_input = 1; run(4);
    spi_cs_n = 1; pin0_as_input = 0; sleep = 0; run(70);

    finish_run();
  end

endmodule